// File: doc/BRIEF.md
# Packed SIMD Multiply Unit

This block multiplies two 32-bit operands in one of several lane arrangements. It can form two independent 16×16 products or four independent 8×8 products in one pass. It can add or subtract the two halfword products into a single word, or add the four byte products into a single word. It can also multiply one halfword of the first operand by the whole second operand. An opcode selects the arrangement. One opcode bit selects signed or unsigned treatment of every lane.

The unit is fully pipelined. It accepts one operation on every clock in which `in_valid_i` is high. The result appears with `out_valid_o` at a fixed latency, with no handshake. Lane-partitioned forms return 64 bits. Reduction and mixed-width forms return 32 bits in the low half of the result, with the upper half zero.

Top module: `simd_mul_unit`

## Requirements
- R1: Opcode `op_i[2:0]`=000 (dual halfword) multiplies halfword i of A (bits 16i+15..16i) by halfword i of B and places the low 32 bits of that product at `result_o[32i+31:32i]`, for i=0,1.
- R2: Opcode 001 (quad byte) multiplies byte i of A by byte i of B and places the low 16 bits of that product at `result_o[16i+15:16i]`, for i=0..3.
- R3: Opcodes 010 and 011 multiply the low halfword (010) or the high halfword (011) of A by all 32 bits of B. `result_o[31:0]` holds bits 47..16 of the 48-bit product, and `result_o[63:32]` is zero.
- R4: Opcode 100 returns the sum of the two halfword products, and opcode 101 returns product 0 minus product 1. Both results are taken modulo 2^32 in `result_o[31:0]`, with zero in the upper half.
- R5: Opcode 110 returns the sum of the four byte products, taken modulo 2^32, in `result_o[31:0]`, with zero in the upper half.
- R6: `op_i[3]`=1 treats every lane of both operands, and the full B word in R3, as two's complement. `op_i[3]`=0 treats them as unsigned. Lane products are sign-extended or zero-extended to match before any reduction.
- R7: An operation that is sampled with `in_valid_i` high at a rising clock edge produces `out_valid_o` high, together with its result, after the next rising edge. Back-to-back operations produce back-to-back results.
- R8: Opcode 111 in either signedness is invalid. It produces `err_o`=1 with `out_valid_o`=1 and `result_o`=0.
- R9: While `rst_ni` is low, `out_valid_o`, `err_o` and `result_o` are all 0.
- R10: In any cycle in which `out_valid_o` is 0, `result_o` and `err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | [3] signed select, [2:0] operation |
| src_a_i | input | 32 | Operand A |
| src_b_i | input | 32 | Operand B |
| out_valid_o | output | 1 | Result present this cycle |
| result_o | output | 64 | Packed or reduced result |
| err_o | output | 1 | Invalid opcode flag, valid with out_valid_o |

## Verification
The hardest case to reach is a signed reduction in which extreme lane products cancel or wrap, for example -128×-128 next to 127×-128 in the byte dot form. Random operands almost never hit these. The bench therefore crosses a fixed set of lane corner words (0, all ones, 0x80/0x7F lane mixes, and single-one lanes) against each other under every opcode, then adds pseudo-random pairs. Bubbles are interleaved into the stream so that the latency and idle-zero behaviour is checked with both adjacent and separated operations.

// File: rtl/simd_mul_pkg.sv
package simd_mul_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [2:0] {
    K_MUL2H = 3'd0,
    K_MUL4B = 3'd1,
    K_MULHL = 3'd2,
    K_MULHH = 3'd3,
    K_SUM2H = 3'd4,
    K_DIF2H = 3'd5,
    K_DOT4B = 3'd6,
    K_BAD   = 3'd7
  } kind_e;

  typedef struct packed {
    logic  valid;
    logic  err;
    logic  sgn;
    kind_e kind;
  } ctrl_t;
endpackage

// File: rtl/simd_mul_decode.sv
module simd_mul_decode
  import simd_mul_pkg::*;
(
  input  logic            valid_i,
  input  logic [OP_W-1:0] op_i,
  output ctrl_t           ctrl_o
);
  always_comb begin
    ctrl_o.valid = valid_i;
    ctrl_o.sgn   = op_i[OP_W-1];
    ctrl_o.kind  = kind_e'(op_i[2:0]);
    ctrl_o.err   = valid_i && (op_i[2:0] == K_BAD);
  end
endmodule

// File: rtl/simd_mul_lanes.sv
module simd_mul_lanes
  import simd_mul_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned HALF_W = DATA_W / 2,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned NH     = DATA_W / HALF_W,
  parameter int unsigned NB     = DATA_W / BYTE_W
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  ctrl_t                          ctrl_i,
  input  logic [DATA_W-1:0]              a_i,
  input  logic [DATA_W-1:0]              b_i,
  output ctrl_t                          ctrl_o,
  output logic [NH-1:0][2*HALF_W-1:0]    hprod_o,
  output logic [NB-1:0][2*BYTE_W-1:0]    bprod_o,
  output logic [DATA_W-1:0]              wprod_o
);
  localparam int unsigned HP_W = 2 * HALF_W;
  localparam int unsigned BP_W = 2 * BYTE_W;
  localparam int unsigned WP_W = HALF_W + DATA_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_o <= '0;
    else         ctrl_o <= ctrl_i;
  end

  // halfword lanes: product computed at output width, low bits exact for both signs
  for (genvar h = 0; h < NH; h++) begin : g_half
    logic [HALF_W-1:0] la, lb;
    logic [HP_W-1:0]   ea, eb, p;
    assign la = a_i[h*HALF_W +: HALF_W];
    assign lb = b_i[h*HALF_W +: HALF_W];
    assign ea = {{(HP_W-HALF_W){ctrl_i.sgn & la[HALF_W-1]}}, la};
    assign eb = {{(HP_W-HALF_W){ctrl_i.sgn & lb[HALF_W-1]}}, lb};
    assign p  = ea * eb;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           hprod_o[h] <= '0;
      else if (ctrl_i.valid) hprod_o[h] <= p;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic [BYTE_W-1:0] la, lb;
    logic [BP_W-1:0]   ea, eb, p;
    assign la = a_i[b*BYTE_W +: BYTE_W];
    assign lb = b_i[b*BYTE_W +: BYTE_W];
    assign ea = {{(BP_W-BYTE_W){ctrl_i.sgn & la[BYTE_W-1]}}, la};
    assign eb = {{(BP_W-BYTE_W){ctrl_i.sgn & lb[BYTE_W-1]}}, lb};
    assign p  = ea * eb;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           bprod_o[b] <= '0;
      else if (ctrl_i.valid) bprod_o[b] <= p;
    end
  end

  // mixed-width lane: halfword of A times full B, keep product bits above HALF_W
  logic [HALF_W-1:0] wsel;
  logic [WP_W-1:0]   wa, wb, wp;
  logic [DATA_W-1:0] wkeep;
  logic [HALF_W-1:0] unused_wlo;

  assign wsel = (ctrl_i.kind == K_MULHH) ? a_i[DATA_W-1 -: HALF_W] : a_i[HALF_W-1:0];
  assign wa   = {{(WP_W-HALF_W){ctrl_i.sgn & wsel[HALF_W-1]}}, wsel};
  assign wb   = {{(WP_W-DATA_W){ctrl_i.sgn & b_i[DATA_W-1]}}, b_i};
  assign wp   = wa * wb;
  assign {wkeep, unused_wlo} = wp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           wprod_o <= '0;
    else if (ctrl_i.valid) wprod_o <= wkeep;
  end
endmodule

// File: rtl/simd_mul_combine.sv
module simd_mul_combine
  import simd_mul_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned HALF_W = DATA_W / 2,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned NH     = DATA_W / HALF_W,
  parameter int unsigned NB     = DATA_W / BYTE_W,
  parameter int unsigned RES_W  = 2 * DATA_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  ctrl_t                       ctrl_i,
  input  logic [NH-1:0][2*HALF_W-1:0] hprod_i,
  input  logic [NB-1:0][2*BYTE_W-1:0] bprod_i,
  input  logic [DATA_W-1:0]           wprod_i,
  output logic                        valid_o,
  output logic [RES_W-1:0]            result_o,
  output logic                        err_o
);
  localparam int unsigned HP_W = 2 * HALF_W;
  localparam int unsigned BP_W = 2 * BYTE_W;

  logic [DATA_W-1:0] hsum, hdif, bsum;
  logic [RES_W-1:0]  hpack, bpack, res_d;

  always_comb begin
    hsum  = '0;
    hdif  = DATA_W'(hprod_i[0]);
    hpack = '0;
    for (int h = 0; h < NH; h++) begin
      hsum = hsum + DATA_W'(hprod_i[h]);
      if (h > 0) hdif = hdif - DATA_W'(hprod_i[h]);
      hpack[h*HP_W +: HP_W] = hprod_i[h];
    end
  end

  always_comb begin
    bsum  = '0;
    bpack = '0;
    for (int b = 0; b < NB; b++) begin
      bsum = bsum + {{(DATA_W-BP_W){ctrl_i.sgn & bprod_i[b][BP_W-1]}}, bprod_i[b]};
      bpack[b*BP_W +: BP_W] = bprod_i[b];
    end
  end

  always_comb begin
    unique case (ctrl_i.kind)
      K_MUL2H:          res_d = hpack;
      K_MUL4B:          res_d = bpack;
      K_MULHL, K_MULHH: res_d = RES_W'(wprod_i);
      K_SUM2H:          res_d = RES_W'(hsum);
      K_DIF2H:          res_d = RES_W'(hdif);
      K_DOT4B:          res_d = RES_W'(bsum);
      default:          res_d = '0;
    endcase
    if (!ctrl_i.valid || ctrl_i.err) res_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      err_o    <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o  <= ctrl_i.valid;
      err_o    <= ctrl_i.valid & ctrl_i.err;
      result_o <= res_d;
    end
  end
endmodule

// File: rtl/simd_mul_unit.sv
module simd_mul_unit
  import simd_mul_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned HALF_W = DATA_W / 2,
  localparam int unsigned NH     = DATA_W / HALF_W,
  localparam int unsigned NB     = DATA_W / BYTE_W,
  localparam int unsigned RES_W  = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  output logic              out_valid_o,
  output logic [RES_W-1:0]  result_o,
  output logic              err_o
);
  ctrl_t                       ctrl_d, ctrl_q;
  logic [NH-1:0][2*HALF_W-1:0] hprod;
  logic [NB-1:0][2*BYTE_W-1:0] bprod;
  logic [DATA_W-1:0]           wprod;

  simd_mul_decode u_dec (
    .valid_i (in_valid_i),
    .op_i    (op_i),
    .ctrl_o  (ctrl_d)
  );

  simd_mul_lanes #(
    .DATA_W (DATA_W), .HALF_W (HALF_W), .BYTE_W (BYTE_W), .NH (NH), .NB (NB)
  ) u_lanes (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ctrl_i  (ctrl_d),
    .a_i     (src_a_i),
    .b_i     (src_b_i),
    .ctrl_o  (ctrl_q),
    .hprod_o (hprod),
    .bprod_o (bprod),
    .wprod_o (wprod)
  );

  simd_mul_combine #(
    .DATA_W (DATA_W), .HALF_W (HALF_W), .BYTE_W (BYTE_W), .NH (NH), .NB (NB), .RES_W (RES_W)
  ) u_comb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctrl_i   (ctrl_q),
    .hprod_i  (hprod),
    .bprod_i  (bprod),
    .wprod_i  (wprod),
    .valid_o  (out_valid_o),
    .result_o (result_o),
    .err_o    (err_o)
  );
endmodule

// File: rtl/simd_mul_unit_chk.sv
module simd_mul_unit_chk #(
  parameter int unsigned RES_W = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic [2:0]       kind_i,
  input logic             out_valid_o,
  input logic [RES_W-1:0] result_o,
  input logic             err_o
);
  localparam int unsigned HALF_R = RES_W / 2;

  logic       v_d1, v_d2;
  logic [2:0] k_d1, k_d2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_d1 <= 1'b0; v_d2 <= 1'b0; k_d1 <= '0; k_d2 <= '0;
    end else begin
      v_d1 <= in_valid_i; v_d2 <= v_d1; k_d1 <= kind_i; k_d2 <= k_d1;
    end
  end

  AST_LATENCY_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == v_d2); // R7
  AST_ERR_ON_BAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (err_o == (k_d2 == 3'd7))); // R8
  AST_ERR_ZERO_RES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (out_valid_o && result_o == '0)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> (result_o == '0 && !err_o)); // R10
  AST_NARROW_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && k_d2 >= 3'd2 && k_d2 <= 3'd6) |-> (result_o[RES_W-1:HALF_R] == '0)); // R4
endmodule

bind simd_mul_unit simd_mul_unit_chk #(.RES_W (RES_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .kind_i      (op_i[2:0]),
  .out_valid_o (out_valid_o),
  .result_o    (result_o),
  .err_o       (err_o)
);

// File: tb/simd_mul_unit_test.sv
`timescale 1ns/1ps
module simd_mul_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic [31:0] src_a = '0, src_b = '0;
  logic        out_valid;
  logic [63:0] result;
  logic        err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic        e1_v = 1'b0, e2_v = 1'b0;
  logic [64:0] e1_x = '0, e2_x = '0;
  logic [3:0]  e1_op = '0, e2_op = '0;

  always #2 clk = ~clk;

  simd_mul_unit uut (
    .clk_i (clk), .rst_ni (rst_n), .in_valid_i (in_valid), .op_i (op),
    .src_a_i (src_a), .src_b_i (src_b),
    .out_valid_o (out_valid), .result_o (result), .err_o (err)
  );

  function automatic longint lane(logic [31:0] w, int lsb, int width, bit s);
    longint v = (longint'(w) >> lsb) & ((longint'(1) << width) - 1);
    if (s && v[width-1]) v = v - (longint'(1) << width);
    return v;
  endfunction

  // {err, result} from the requirement arithmetic
  function automatic logic [64:0] expect_of(logic [3:0] o, logic [31:0] a, logic [31:0] b);
    logic [63:0] r = '0;
    bit s = o[3];
    longint p, acc;
    case (o[2:0])
      3'd0: for (int h = 0; h < 2; h++) begin
              p = lane(a, 16*h, 16, s) * lane(b, 16*h, 16, s);
              r[32*h +: 32] = p[31:0];
            end
      3'd1: for (int i = 0; i < 4; i++) begin
              p = lane(a, 8*i, 8, s) * lane(b, 8*i, 8, s);
              r[16*i +: 16] = p[15:0];
            end
      3'd2, 3'd3: begin
              p = lane(a, (o[2:0] == 3'd3) ? 16 : 0, 16, s) * lane(b, 0, 32, s);
              p = p >>> 16;
              r[31:0] = p[31:0];
            end
      3'd4, 3'd5: begin
              acc = lane(a, 0, 16, s) * lane(b, 0, 16, s);
              p   = lane(a, 16, 16, s) * lane(b, 16, 16, s);
              acc = (o[2:0] == 3'd4) ? acc + p : acc - p;
              r[31:0] = acc[31:0];
            end
      3'd6: begin
              acc = 0;
              for (int i = 0; i < 4; i++) acc += lane(a, 8*i, 8, s) * lane(b, 8*i, 8, s);
              r[31:0] = acc[31:0];
            end
      default: return {1'b1, 64'h0};
    endcase
    return {1'b0, r};
  endfunction

  function automatic string tag_of(logic [3:0] o);
    string t;
    case (o[2:0])
      3'd0: t = "R1"; 3'd1: t = "R2"; 3'd2, 3'd3: t = "R3";
      3'd4, 3'd5: t = "R4"; 3'd6: t = "R5"; default: t = "R8";
    endcase
    if (o[3]) t = {t, "/R6"};
    return {t, "/R7"};
  endfunction

  task automatic chk(string req, logic [65:0] act, logic [65:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] corner(int i);
    case (i)
      0: return 32'h0000_0000; 1: return 32'hFFFF_FFFF;
      2: return 32'h8000_8000; 3: return 32'h7FFF_7FFF;
      4: return 32'h8080_7F7F; 5: return 32'h0001_0001;
      6: return 32'h7F80_FF01; default: return 32'h1234_5678;
    endcase
  endfunction

  // negedge: check the op driven two steps earlier, then drive the next
  task automatic step(logic v, logic [3:0] o, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    if (e2_v) chk(tag_of(e2_op), {out_valid, err, result}, {1'b1, e2_x});
    else      chk("R10/R7 idle", {out_valid, err, result}, 66'h0);
    e2_v = e1_v; e2_x = e1_x; e2_op = e1_op;
    e1_v = v; e1_x = v ? expect_of(o, a, b) : 65'h0; e1_op = o;
    in_valid = v; op = o; src_a = a; src_b = b;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    logic [31:0] seed = 32'h1ACE_B00C;
    int cnt = 0;
    repeat (3) @(negedge clk);
    chk("R9 reset", {out_valid, err, result}, 66'h0);
    rst_n = 1'b1;
    for (int o = 0; o < 16; o++) begin
      for (int k = 0; k < 128; k++) begin
        logic [31:0] a, b;
        if (k < 64) begin
          a = corner(k / 8); b = corner(k % 8);
        end else begin
          seed = seed * 32'd1664525 + 32'd1013904223; a = seed;
          seed = seed * 32'd1664525 + 32'd1013904223; b = seed;
        end
        cnt++;
        if (cnt % 7 == 0) step(1'b0, 4'h0, 32'hDEAD_BEEF, 32'hFFFF_FFFF);
        step(1'b1, 4'(o), a, b);
      end
    end
    repeat (3) step(1'b0, 4'h0, '0, '0);
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog R7 actual=hung expected=complete");
      finish_run();
    end
  end
endmodule